// File: doc/BRIEF.md
# Row-Streaming Template Correlator

The block scores how well a stored 7x7 pattern of 8-bit weights matches every position of a 25x25 pixel window. The window arrives one row per accepted cycle, with all 25 pixels of the row side by side. For every map column there is one correlation lane. Each lane multiplies the current image row against all seven template rows at once.

Each lane keeps a short chain of partial sums. Each link in the chain adds one more template row. A map row is therefore complete in the same cycle as the last image row that it needs. A frame of 25 rows yields the whole 25x25 map, one registered row per accepted input row.

Each weight is split into a low and a high 4-bit half. The two halves are summed separately, and the high sum is scaled by 16 before the two are combined. A start pulse opens a new frame and discards any partial sums left from an earlier frame.

Top module: `tmpl_corr_top`

## Requirements
- R1: For map row r and column c (both 0..24), the score is the sum over a,b in 0..6 of T[a][b] * P[r-6+a][c-6+b]. Here P[y][x] is the pixel of row y and column x, and it counts as zero when y or x is negative. The template byte T[a][b] sits at `tmpl_i[8*(7*a+b) +: 8]`, pixel column x of the row at `row_pix_i[8*x +: 8]`, and score column c at `map_row_o[22*c +: 22]`.
- R2: One cycle after the k-th accepted row of a frame (counting from 0), `map_vld_o` is high for that cycle and `map_idx_o` equals k. Rows are emitted in increasing order.
- R3: With every pixel and weight at 255, each score whose full 7x7 neighbourhood lies inside the window equals 3186225. No score wraps.
- R4: Map rows 0 to 5 take in only the image rows that exist, so the rows above the window contribute nothing.
- R5: A start pulse on its own produces no output and discards every partial sum. A frame begun after an aborted frame gives the same map as a frame begun from a clean state.
- R6: When a start pulse and a row arrive in the same cycle, that row is taken as row 0 of the new frame, with no history from before.
- R7: A cycle with `row_vld_i` low emits nothing and leaves the frame in progress intact.
- R8: Once 25 rows of a frame have been accepted, further rows are ignored until the next start pulse. They produce no `map_vld_o`, and `map_idx_o` keeps its last value.
- R9: The high half of each weight carries 16 times the weight of the low half. Templates built only from high halves, or only from low halves, both give the scores of R1.
- R10: After synchronous reset, `map_vld_o`, `map_idx_o` and `map_row_o` are zero. The first 25 rows that follow form a frame without any start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a new frame, clears partial sums |
| row_vld_i | input | 1 | A window row is present on `row_pix_i` |
| row_pix_i | input | 200 | 25 pixels of 8 bits, column x at bits 8x |
| tmpl_i | input | 392 | 49 template bytes, entry (a,b) at byte 7a+b |
| map_vld_o | output | 1 | A completed map row is on `map_row_o` |
| map_idx_o | output | 5 | Index of the map row being emitted |
| map_row_o | output | 550 | 25 scores of 22 bits, column c at bits 22c |

## Verification
A frame start and the acceptance of a row can fall in the same cycle. When they do, the clear must win over the stored partial sums while the new row is still added in. The bench provokes this by aborting a frame partway, with its delay chains still loaded. It then raises the start pulse together with row 0 of a different pattern and compares every row of the new map with a reference computed only from the new frame. Further table entries open frames with the start pulse and row 0 together, as well as with a separate start pulse. Those entries check that row 0 of the new frame comes out as map row 0.

// File: rtl/corr_pkg.sv
package corr_pkg;
  // Largest sum a lane half can reach: taps * max pixel * max nibble.
  function automatic longint unsigned half_bound(input int taps, input int pix_w, input int nib_w);
    return longint'(taps) * ((longint'(1) << pix_w) - 1) * ((longint'(1) << nib_w) - 1);
  endfunction

  // Full-scale score for a whole neighbourhood.
  function automatic longint unsigned score_bound(input int taps, input int pix_w, input int wgt_w);
    return longint'(taps) * longint'(taps) * ((longint'(1) << pix_w) - 1) * ((longint'(1) << wgt_w) - 1);
  endfunction
endpackage

// File: rtl/corr_lane.sv
module corr_lane #(
  parameter int TAP    = 7,
  parameter int PIX_W  = 8,
  parameter int WGT_W  = 8,
  parameter int RSUM_W = 19
) (
  input  logic [TAP*PIX_W-1:0]     pix_i,
  input  logic [TAP*TAP*WGT_W-1:0] wgt_i,
  output logic [TAP*RSUM_W-1:0]    rsum_o
);
  localparam int NIB_W  = WGT_W / 2;
  localparam int PROD_W = PIX_W + NIB_W;
  localparam int HSUM_W = PROD_W + $clog2(TAP);

  for (genvar a = 0; a < TAP; a++) begin : g_trow
    logic [HSUM_W-1:0] lo_s;
    logic [HSUM_W-1:0] hi_s;

    always_comb begin
      lo_s = '0;
      hi_s = '0;
      for (int b = 0; b < TAP; b++) begin
        lo_s = lo_s + HSUM_W'(pix_i[b*PIX_W +: PIX_W]) *
                      HSUM_W'(wgt_i[(a*TAP+b)*WGT_W +: NIB_W]);
        hi_s = hi_s + HSUM_W'(pix_i[b*PIX_W +: PIX_W]) *
                      HSUM_W'(wgt_i[(a*TAP+b)*WGT_W + NIB_W +: NIB_W]);
      end
    end

    // High half weighs 2**NIB_W times the low half.
    assign rsum_o[a*RSUM_W +: RSUM_W] = (RSUM_W'(hi_s) << NIB_W) + RSUM_W'(lo_s);
  end
endmodule

// File: rtl/corr_chain.sv
module corr_chain #(
  parameter int TAP     = 7,
  parameter int RSUM_W  = 19,
  parameter int SCORE_W = 22
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_i,
  input  logic                  adv_i,
  input  logic [TAP*RSUM_W-1:0] rsum_i,
  output logic [SCORE_W-1:0]    score_o
);
  localparam int NLINK = TAP - 1;

  logic [SCORE_W-1:0] acc_q [NLINK];
  logic [SCORE_W-1:0] base  [NLINK];
  logic [SCORE_W-1:0] rs    [TAP];
  logic [SCORE_W-1:0] score_q;

  always_comb begin
    for (int s = 0; s < TAP; s++) rs[s] = SCORE_W'(rsum_i[s*RSUM_W +: RSUM_W]);
    for (int s = 0; s < NLINK; s++) base[s] = clr_i ? '0 : acc_q[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NLINK; s++) acc_q[s] <= '0;
      score_q <= '0;
    end else if (adv_i) begin
      acc_q[0] <= rs[0];
      for (int s = 1; s < NLINK; s++) acc_q[s] <= base[s-1] + rs[s];
      score_q <= base[NLINK-1] + rs[TAP-1];
    end else if (clr_i) begin
      for (int s = 0; s < NLINK; s++) acc_q[s] <= '0;
    end
  end

  assign score_o = score_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> (score_q >= $past(base[NLINK-1]))); // R3
endmodule

// File: rtl/corr_ctrl.sv
module corr_ctrl #(
  parameter int WIN   = 25,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             row_vld_i,
  output logic             accept_o,
  output logic             map_vld_o,
  output logic [IDX_W-1:0] map_idx_o
);
  localparam int CNT_W = $clog2(WIN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur;
  logic             vld_q;
  logic [IDX_W-1:0] idx_q;

  assign cur      = start_i ? '0 : cnt_q;
  assign accept_o = row_vld_i && (start_i || (cnt_q < CNT_W'(WIN)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= accept_o;
      if (accept_o) begin
        idx_q <= IDX_W'(cur);
        cnt_q <= cur + CNT_W'(1);
      end else if (start_i) begin
        cnt_q <= '0;
      end
    end
  end

  assign map_vld_o = vld_q;
  assign map_idx_o = idx_q;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    map_vld_o |-> (map_idx_o < IDX_W'(WIN))); // R2
  AST_START_ROW0: assert property (@(posedge clk) disable iff (rst)
    (start_i && row_vld_i) |=> (map_vld_o && map_idx_o == '0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !row_vld_i |=> !map_vld_o); // R7
  AST_FRAME_CAP: assert property (@(posedge clk) disable iff (rst)
    (row_vld_i && !start_i && cnt_q == CNT_W'(WIN)) |=> (!map_vld_o && $stable(map_idx_o))); // R8
endmodule

// File: rtl/tmpl_corr_top.sv
module tmpl_corr_top #(
  parameter int WIN     = 25,
  parameter int TAP     = 7,
  parameter int PIX_W   = 8,
  parameter int WGT_W   = 8,
  parameter int SCORE_W = 22,
  parameter int IDX_W   = $clog2(WIN)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic                     row_vld_i,
  input  logic [WIN*PIX_W-1:0]     row_pix_i,
  input  logic [TAP*TAP*WGT_W-1:0] tmpl_i,
  output logic                     map_vld_o,
  output logic [IDX_W-1:0]         map_idx_o,
  output logic [WIN*SCORE_W-1:0]   map_row_o
);
  import corr_pkg::*;

  localparam int RSUM_W = PIX_W + WGT_W + $clog2(TAP);
  localparam int PAD_N  = WIN + TAP - 1;

  // Columns left of the window read as zero.
  logic [PAD_N*PIX_W-1:0] pad_row;
  logic                   accept;

  assign pad_row = {row_pix_i, {(TAP-1)*PIX_W{1'b0}}};

  corr_ctrl #(.WIN(WIN), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .row_vld_i (row_vld_i),
    .accept_o  (accept),
    .map_vld_o (map_vld_o),
    .map_idx_o (map_idx_o)
  );

  for (genvar c = 0; c < WIN; c++) begin : g_col
    logic [TAP*RSUM_W-1:0] rsum;

    corr_lane #(.TAP(TAP), .PIX_W(PIX_W), .WGT_W(WGT_W), .RSUM_W(RSUM_W)) u_lane (
      .pix_i  (pad_row[c*PIX_W +: TAP*PIX_W]),
      .wgt_i  (tmpl_i),
      .rsum_o (rsum)
    );

    corr_chain #(.TAP(TAP), .RSUM_W(RSUM_W), .SCORE_W(SCORE_W)) u_chain (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (start_i),
      .adv_i   (accept),
      .rsum_i  (rsum),
      .score_o (map_row_o[c*SCORE_W +: SCORE_W])
    );
  end

  initial begin
    AST_SCORE_FITS: assert (score_bound(TAP, PIX_W, WGT_W) < (longint'(1) << SCORE_W)); // R3
  end
endmodule

// File: tb/sim_tmpl_corr_top.sv
module sim_tmpl_corr_top;
  localparam int CLK_P = 10;
  localparam int WIN   = 25;
  localparam int TAP   = 7;
  localparam int SW    = 22;
  localparam int NV    = 6;
  // fields: template mode [11:8], pixel mode [7:4], start mode [3:0]
  localparam logic [11:0] VEC [NV] = '{12'h000, 12'h111, 12'h220, 12'h321, 12'h132, 12'h442};

  logic clk = 0, rst = 1, start = 0, rvld = 0;
  logic [WIN*8-1:0]     rpix = '0;
  logic [TAP*TAP*8-1:0] tmpl = '0;
  logic                 mvld;
  logic [4:0]           midx;
  logic [WIN*SW-1:0]    mrow;

  int img [WIN][WIN];
  int tm  [TAP][TAP];
  int nchk = 0, nerr = 0;

  always #(CLK_P/2) clk = ~clk;

  tmpl_corr_top u0 (.clk(clk), .rst(rst), .start_i(start), .row_vld_i(rvld),
    .row_pix_i(rpix), .tmpl_i(tmpl), .map_vld_o(mvld), .map_idx_o(midx), .map_row_o(mrow));

  function automatic int tval(int m, int a, int b);
    case (m)
      0: return 255;
      1: return (a*37 + b*11 + 5) & 255;
      2: return ((a + b) & 15) << 4;
      3: return (a*7 + b) & 15;
      default: return (a == 6 && b == 6) ? 1 : 0;
    endcase
  endfunction

  function automatic int pval(int m, int y, int x);
    case (m)
      0: return 255;
      1: return (y*29 + x*13 + y*x) & 255;
      2: return (x*10 + y) & 255;
      3: return 255 - (((x + y) * 9) & 255);
      default: return (y*3 + x*7) & 255;
    endcase
  endfunction

  function automatic int exp_score(int r, int c);
    int s = 0;
    for (int a = 0; a < TAP; a++)
      for (int b = 0; b < TAP; b++) begin
        int y = r - 6 + a;
        int x = c - 6 + b;
        if (y >= 0 && x >= 0) s += tm[a][b] * img[y][x];
      end
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [1023:0] act, input logic [1023:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_case(input int tmode, input int pmode);
    for (int a = 0; a < TAP; a++)
      for (int b = 0; b < TAP; b++) begin
        tm[a][b] = tval(tmode, a, b);
        tmpl[8*(7*a+b) +: 8] = 8'(tm[a][b]);
      end
    for (int y = 0; y < WIN; y++)
      for (int x = 0; x < WIN; x++) img[y][x] = pval(pmode, y, x);
  endtask

  // Drives one cycle of inputs at a falling edge; returns at the next falling edge.
  task automatic step(input bit v, input bit s, input int y);
    rvld  = v;
    start = s;
    if (v) for (int x = 0; x < WIN; x++) rpix[8*x +: 8] = 8'(img[y][x]);
    @(negedge clk);
    rvld  = 0;
    start = 0;
  endtask

  task automatic check_out(input int r, input string req);
    logic [WIN*SW-1:0] e;
    for (int c = 0; c < WIN; c++) e[c*SW +: SW] = SW'(exp_score(r, c));
    chk(mvld === 1'b1 && midx === 5'(r), "R2", "valid/index", {mvld, 3'b0, midx}, {1'b1, 3'b0, 5'(r)});
    chk(mrow === e, req, "map row", mrow, e);
  endtask

  task automatic run_frame(input int smode, input string tag);
    if (smode == 0) begin
      step(1'b0, 1'b1, 0);
      chk(mvld === 1'b0, "R5", "lone start emits", mvld, 0);
    end
    for (int y = 0; y < WIN; y++) begin
      bit s = (smode != 0 && y == 0);
      step(1'b1, s, y);
      check_out(y, s ? "R6" : (y < 6 ? "R4" : tag));
      if (smode == 2 && y == 9) begin
        step(1'b0, 1'b0, 0);
        chk(mvld === 1'b0, "R7", "idle emits", mvld, 0);
        step(1'b0, 1'b0, 0);
        chk(mvld === 1'b0, "R7", "idle emits", mvld, 0);
      end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    load_case(1, 1);
    repeat (3) @(negedge clk);
    chk(mvld === 1'b0 && midx === 5'd0 && mrow === '0, "R10", "reset state", {mvld, midx}, 0);
    rst = 0;
    @(negedge clk);

    // R10: a frame straight after reset, no start pulse
    for (int y = 0; y < WIN; y++) begin
      step(1'b1, 1'b0, y);
      check_out(y, "R10");
    end
    // R8: extra rows after a full frame are ignored
    step(1'b1, 1'b0, 3);
    chk(mvld === 1'b0 && midx === 5'd24, "R8", "row past frame end", {mvld, midx}, {1'b0, 5'd24});
    step(1'b1, 1'b0, 4);
    chk(mvld === 1'b0 && midx === 5'd24, "R8", "row past frame end", {mvld, midx}, {1'b0, 5'd24});

    // vector table
    for (int i = 0; i < NV; i++) begin
      int tmode = int'(VEC[i][11:8]);
      int pmode = int'(VEC[i][7:4]);
      int smode = int'(VEC[i][3:0]);
      string tag = (tmode == 0 && pmode == 0) ? "R3" : ((tmode == 2 || tmode == 3) ? "R9" : "R1");
      load_case(tmode, pmode);
      run_frame(smode, tag);
    end

    // R3: a single full-scale score spelled out
    load_case(0, 0);
    run_frame(1, "R3");
    chk(mrow[24*SW +: SW] === 22'd3186225, "R3", "full-scale corner", mrow[24*SW +: SW], 22'd3186225);

    // R5: aborted frame followed by a lone start pulse
    load_case(1, 2);
    for (int y = 0; y < 10; y++) step(1'b1, y == 0, y);
    load_case(3, 1);
    run_frame(0, "R5");

    // R5/R6: aborted frame, then start together with row 0
    load_case(2, 3);
    for (int y = 0; y < 5; y++) step(1'b1, y == 0, y);
    load_case(1, 1);
    run_frame(1, "R5");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule